// File: doc/BRIEF.md
# Programmable Periodic Interrupt Clock

This block is a real-time interval clock for a minicomputer-style I/O bus. Software picks one of four interval lengths with a small rate selector, written through the accumulator data-out strobe. A start pulse then arms a countdown that measures the chosen interval in ticks. The block never sees wall-clock time: a tick-enable input marks each unit of time, and the countdown moves only on cycles where that input is high.

When an interval runs out, the block sets its done flag, drops busy and raises an interrupt request unless the disable mask is set. It then reloads at once from whichever interval the selector names at that moment and keeps running without another start pulse. A one-cycle expiry strobe marks every expiry, so each period stays visible at the ports while done is held. The four interval counts sit in a table of 24-bit entries. A configuration port can rewrite the table, but it refuses zero so that no entry can become empty.

Top module: `periodic_irq_clock`

## Requirements
- R1: After reset the selector is 0, busy, done, irq and period_pulse are 0, and the countdown is stopped, so ticks alone never set done.
- R2: An acc_wr cycle loads the selector from acc_data[1:0]. A start or an expiry in that same cycle already uses the new selector.
- R3: Table entries reset to 16000 (selector 0), 100000 (selector 1), 10000 (selector 2) and 1000 (selector 3).
- R4: A cfg_wr with a nonzero cfg_val replaces entry cfg_idx from the next cycle on. A cfg_wr with cfg_val equal to 0 leaves the entry unchanged.
- R5: A start_pls without clear_pls sets busy and clears done and irq on the next cycle, and loads the countdown with the selected entry.
- R6: A clear_pls clears busy, done and irq on the next cycle and stops the countdown. It wins over a start_pls in the same cycle.
- R7: The countdown moves only on tick_en cycles. An interval of N expires on the Nth tick after start: done rises and busy falls on the clock edge that takes that tick.
- R8: Every expiry gives a one-cycle period_pulse with done high. The countdown reloads from the entry the selector names at that moment and keeps running.
- R9: irq equals done AND NOT irq_mask, registered. A change of irq_mask shows on irq one cycle later, with no expiry needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One time unit elapses on this cycle |
| acc_wr | input | 1 | Data-out strobe: load selector |
| acc_data | input | ACC_W | Accumulator value; bits [1:0] are used |
| start_pls | input | 1 | Start pulse |
| clear_pls | input | 1 | Clear pulse |
| irq_mask | input | 1 | Interrupt disable mask |
| cfg_wr | input | 1 | Interval table write strobe |
| cfg_idx | input | SEL_W | Table entry to write |
| cfg_val | input | CNT_W | New interval count (0 ignored) |
| busy | output | 1 | Countdown armed, first interval not yet expired |
| done | output | 1 | An interval has expired |
| irq | output | 1 | Interrupt request |
| period_pulse | output | 1 | One-cycle strobe on each expiry |

## Verification
A wrong countdown value shows up as a done edge or period_pulse one or more ticks away from the Nth tick after a start or a reload. A cycle-exact model flags it on the first cycle the strobe is early or late. A selector or table fault shows as the wrong interval length on the next start or reload. A stale irq register shows as irq disagreeing with done and the mask one cycle after the mask changes. Random mixes of overlapping start, clear, selector and table writes against the model expose wrong priority or wrong same-cycle selector use in the cycle that follows.

// File: rtl/pic_pkg.sv
package pic_pkg;

    // Reset value of each interval table entry, by selector value
    function automatic int unsigned default_interval(input int unsigned idx);
        case (idx)
            0:       return 16000;
            1:       return 100000;
            2:       return 10000;
            default: return 1000;
        endcase
    endfunction

    typedef struct packed {
        logic busy;
        logic done;
        logic irq;
        logic pulse;
    } flags_t;

endpackage

// File: rtl/pic_interval_table.sv
module pic_interval_table #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 24,
    localparam int ENTRIES = 1 << SEL_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [SEL_W-1:0]                wr_idx,
    input  logic [CNT_W-1:0]                wr_val,
    input  logic [SEL_W-1:0]                rd_idx,
    output logic [CNT_W-1:0]                rd_val,
    output logic [ENTRIES-1:0][CNT_W-1:0]   entries
);

    logic wr_ok;
    assign wr_ok = wr_en && (wr_val != '0);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        logic [CNT_W-1:0] ent_d;
        logic [CNT_W-1:0] ent_q;

        always_comb begin
            ent_d = ent_q;
            if (wr_ok && (wr_idx == SEL_W'(g))) begin
                ent_d = wr_val;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= CNT_W'(pic_pkg::default_interval(g));
            end else begin
                ent_q <= ent_d;
            end
        end

        assign entries[g] = ent_q;
    end

    assign rd_val = entries[rd_idx];

endmodule

// File: rtl/pic_countdown.sv
module pic_countdown #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic             clear,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } cd_state_t;

    cd_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (clear) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (start) begin
            st_d.run = 1'b1;
            st_d.cnt = load_val;
        end else if (st_q.run && tick) begin
            if (st_q.cnt == CNT_W'(1)) begin
                expire   = 1'b1;
                st_d.cnt = load_val;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/pic_status.sv
module pic_status (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic clear,
    input  logic expire,
    input  logic mask,
    output logic busy,
    output logic done,
    output logic irq,
    output logic pulse
);

    pic_pkg::flags_t fl_d, fl_q;

    always_comb begin
        fl_d       = fl_q;
        fl_d.pulse = 1'b0;
        if (clear) begin
            fl_d.busy = 1'b0;
            fl_d.done = 1'b0;
        end else if (start) begin
            fl_d.busy = 1'b1;
            fl_d.done = 1'b0;
        end else if (expire) begin
            fl_d.busy  = 1'b0;
            fl_d.done  = 1'b1;
            fl_d.pulse = 1'b1;
        end
        fl_d.irq = fl_d.done && !mask;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fl_q <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end

    assign busy  = fl_q.busy;
    assign done  = fl_q.done;
    assign irq   = fl_q.irq;
    assign pulse = fl_q.pulse;

endmodule

// File: rtl/periodic_irq_clock.sv
module periodic_irq_clock #(
    parameter int ACC_W = 16,
    parameter int SEL_W = 2,
    parameter int CNT_W = 24,
    localparam int ENTRIES = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             acc_wr,
    input  logic [ACC_W-1:0] acc_data,
    input  logic             start_pls,
    input  logic             clear_pls,
    input  logic             irq_mask,
    input  logic             cfg_wr,
    input  logic [SEL_W-1:0] cfg_idx,
    input  logic [CNT_W-1:0] cfg_val,
    output logic             busy,
    output logic             done,
    output logic             irq,
    output logic             period_pulse
);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
    } top_state_t;

    top_state_t ts_d, ts_q;
    logic [SEL_W-1:0]              sel_eff;
    logic [CNT_W-1:0]              load_val;
    logic [ENTRIES-1:0][CNT_W-1:0] tbl_entries;
    logic                          expire;
    logic                          unused_acc;

    assign unused_acc = ^acc_data[ACC_W-1:SEL_W];

    // A selector write in the same cycle governs a start or reload
    always_comb begin
        ts_d    = ts_q;
        sel_eff = acc_wr ? acc_data[SEL_W-1:0] : ts_q.sel;
        ts_d.sel = sel_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_q <= '0;
        end else begin
            ts_q <= ts_d;
        end
    end

    pic_interval_table #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_idx  (cfg_idx),
        .wr_val  (cfg_val),
        .rd_idx  (sel_eff),
        .rd_val  (load_val),
        .entries (tbl_entries)
    );

    pic_countdown #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .start    (start_pls),
        .clear    (clear_pls),
        .load_val (load_val),
        .expire   (expire)
    );

    pic_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_pls),
        .clear  (clear_pls),
        .expire (expire),
        .mask   (irq_mask),
        .busy   (busy),
        .done   (done),
        .irq    (irq),
        .pulse  (period_pulse)
    );

endmodule

// File: rtl/periodic_irq_clock_chk.sv
module periodic_irq_clock_chk #(
    parameter int SEL_W = 2,
    parameter int CNT_W = 24,
    localparam int ENTRIES = 1 << SEL_W
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          start_pls,
    input logic                          clear_pls,
    input logic                          irq_mask,
    input logic                          cfg_wr,
    input logic [CNT_W-1:0]              cfg_val,
    input logic                          busy,
    input logic                          done,
    input logic                          irq,
    input logic                          period_pulse,
    input logic [ENTRIES-1:0][CNT_W-1:0] entries
);

    assert_zero_write_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_val == '0) |=> $stable(entries));

    assert_start_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pls && !clear_pls) |=> (busy && !done && !irq));

    assert_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pls |=> (!busy && !done && !irq));

    assert_busy_done_apart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_pulse_marks_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        period_pulse |-> (done && !busy));

    assert_irq_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);

    assert_irq_unmasked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !irq_mask && !start_pls && !clear_pls) |=> irq);

endmodule

bind periodic_irq_clock periodic_irq_clock_chk #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_pls    (start_pls),
    .clear_pls    (clear_pls),
    .irq_mask     (irq_mask),
    .cfg_wr       (cfg_wr),
    .cfg_val      (cfg_val),
    .busy         (busy),
    .done         (done),
    .irq          (irq),
    .period_pulse (period_pulse),
    .entries      (tbl_entries)
);

// File: tb/periodic_irq_clock_bench.sv
module periodic_irq_clock_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [15:0] acc_data = '0;
    logic        start_pls = 1'b0;
    logic        clear_pls = 1'b0;
    logic        irq_mask = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [1:0]  cfg_idx = '0;
    logic [23:0] cfg_val = '0;
    logic        busy, done, irq, period_pulse;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    periodic_irq_clock u_periodic_irq_clock (
        .clk (clk), .rst_n (rst_n), .tick_en (tick_en),
        .acc_wr (acc_wr), .acc_data (acc_data),
        .start_pls (start_pls), .clear_pls (clear_pls), .irq_mask (irq_mask),
        .cfg_wr (cfg_wr), .cfg_idx (cfg_idx), .cfg_val (cfg_val),
        .busy (busy), .done (done), .irq (irq), .period_pulse (period_pulse)
    );

    // Reference model state
    logic [1:0]  m_sel;
    logic [23:0] m_tab [4];
    logic        m_busy, m_done, m_irq, m_pulse, m_run;
    logic [23:0] m_cnt;

    function automatic logic [23:0] reset_interval(input int i);
        case (i)
            0: return 24'd16000;
            1: return 24'd100000;
            2: return 24'd10000;
            default: return 24'd1000;
        endcase
    endfunction

    task automatic model_reset();
        m_sel = 0; m_busy = 0; m_done = 0; m_irq = 0; m_pulse = 0; m_run = 0; m_cnt = 0;
        for (int i = 0; i < 4; i++) m_tab[i] = reset_interval(i);
    endtask

    task automatic check(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic tk, input logic st, input logic cl, input logic mk,
                        input logic dw, input logic [15:0] dd,
                        input logic cw, input logic [1:0] ci, input logic [23:0] cv);
        logic [1:0]  se;
        logic [23:0] nv;
        tick_en = tk; start_pls = st; clear_pls = cl; irq_mask = mk;
        acc_wr = dw; acc_data = dd; cfg_wr = cw; cfg_idx = ci; cfg_val = cv;
        se = dw ? dd[1:0] : m_sel;
        nv = m_tab[se];
        m_pulse = 0;
        if (cl) begin
            m_busy = 0; m_done = 0; m_run = 0; m_cnt = 0;
        end else if (st) begin
            m_busy = 1; m_done = 0; m_run = 1; m_cnt = nv;
        end else if (m_run && tk) begin
            if (m_cnt == 24'd1) begin
                m_busy = 0; m_done = 1; m_pulse = 1; m_cnt = nv;
            end else begin
                m_cnt = m_cnt - 24'd1;
            end
        end
        m_irq = m_done && !mk;
        m_sel = se;
        if (cw && cv != 0) m_tab[ci] = cv;
        @(posedge clk);
        @(negedge clk);
        check("R5", "busy vs model", busy, m_busy);
        check("R7", "done vs model", done, m_done);
        check("R9", "irq vs model", irq, m_irq);
        check("R8", "period_pulse vs model", period_pulse, m_pulse);
    endtask

    task automatic ticks(input int n, input logic mk);
        for (int i = 0; i < n; i++) step(1, 0, 0, mk, 0, 16'h0, 0, 2'd0, 24'd0);
    endtask

    task automatic idle(input int n, input logic mk);
        for (int i = 0; i < n; i++) step(0, 0, 0, mk, 0, 16'h0, 0, 2'd0, 24'd0);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

    initial begin : main
        void'($urandom(32'd4242));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "busy after reset", busy, 1'b0);
        check("R1", "done after reset", done, 1'b0);
        check("R1", "irq after reset", irq, 1'b0);
        ticks(5, 0);
        check("R1", "counter stopped after reset", done, 1'b0);

        // R2/R3/R5: selector 3 written with start, default 1000 ticks
        step(0, 1, 0, 0, 1, 16'hFFF7, 0, 2'd0, 24'd0);
        check("R5", "busy after start", busy, 1'b1);
        ticks(500, 0);
        idle(7, 0);
        check("R7", "no progress without tick", done, 1'b0);
        ticks(499, 0);
        check("R3", "entry 3 not expired at 999", done, 1'b0);
        ticks(1, 0);
        check("R3", "entry 3 expired at 1000", done, 1'b1);
        check("R7", "busy low at expiry", busy, 1'b0);
        check("R8", "pulse at expiry", period_pulse, 1'b1);

        // R8: reload, then selector change governs next reload
        step(0, 0, 0, 0, 1, 16'h0001, 1, 2'd1, 24'd7);
        ticks(999, 0);
        check("R8", "no pulse before 2nd expiry", period_pulse, 1'b0);
        ticks(1, 0);
        check("R8", "2nd expiry after reload", period_pulse, 1'b1);
        ticks(6, 0);
        check("R2", "no pulse 6 ticks into new interval", period_pulse, 1'b0);
        ticks(1, 0);
        check("R2", "new selector interval of 7", period_pulse, 1'b1);

        // R9: mask toggles irq one cycle later
        check("R9", "irq set with done", irq, 1'b1);
        idle(1, 1);
        check("R9", "irq masked", irq, 1'b0);
        check("R9", "done kept while masked", done, 1'b1);
        idle(1, 0);
        check("R9", "irq back unmasked", irq, 1'b1);

        // R6: clear beats start
        step(1, 1, 1, 0, 0, 16'h0, 0, 2'd0, 24'd0);
        check("R6", "busy after clear+start", busy, 1'b0);
        check("R6", "done after clear+start", done, 1'b0);
        ticks(20, 0);
        check("R6", "stopped after clear", done, 1'b0);

        // R4: zero write ignored (entry 1 stays 7)
        step(0, 0, 0, 0, 0, 16'h0, 1, 2'd1, 24'd0);
        step(0, 1, 0, 0, 0, 16'h0, 0, 2'd0, 24'd0);
        ticks(6, 0);
        check("R4", "entry 1 not expired at 6", done, 1'b0);
        ticks(1, 0);
        check("R4", "entry 1 still 7 after zero write", done, 1'b1);

        // R3: entry 0 default 16000
        step(0, 1, 0, 0, 1, 16'h0004, 0, 2'd0, 24'd0);
        ticks(15999, 0);
        check("R3", "entry 0 not expired at 15999", done, 1'b0);
        ticks(1, 0);
        check("R3", "entry 0 expired at 16000", done, 1'b1);

        // Random mix against the model
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 16'h0, 1, 2'(i), 24'($urandom_range(1, 9)));
        for (int i = 0; i < 5000; i++) begin
            logic tk, st, cl, mk, dw, cw;
            tk = ($urandom_range(0, 9) < 7);
            st = ($urandom_range(0, 29) == 0);
            cl = ($urandom_range(0, 59) == 0);
            mk = ($urandom_range(0, 9) < 2);
            dw = ($urandom_range(0, 14) == 0);
            cw = ($urandom_range(0, 14) == 0);
            step(tk, st, cl, mk, dw, 16'($urandom), cw, 2'($urandom_range(0, 3)),
                 24'($urandom_range(0, 9)));
        end
        summary();
    end

endmodule